// File: doc/BRIEF.md
# Received Packet Header Splitter and Payload Realigner

This block sits on the receive side of a transaction-layer datapath. Packets arrive on a 256-bit streaming bus (eight 32-bit dwords per beat) with valid/ready handshaking, start and end markers and a 2-bit field counting unused 64-bit qwords at the top of the final beat. The first beat of every packet begins with a 3- or 4-dword header in the lowest dword lanes, header dword 0 in bits 31:0. The payload follows at a lane that depends on the header size and on whether the target address is 8-byte aligned. An alignment pad dword may therefore sit between header and payload.

The block decodes the header, strips it together with any pad, and delivers the payload on a second 256-bit stream so that payload dword 0 always lands in lane 0. Payload dwords that do not fit in an output beat are kept in a carry register and merged into the next beat. The header is presented as one 128-bit word alongside the first payload beat. The payload length comes from the header's length field, so the payload end is exact even where the input carries a trailing pad dword. Downstream backpressure reaches the input through the ready signal.

Top module: `tlp_payload_realigner`

## Requirements
- R1: Header dword 0 bit 29 set marks a 4-dword header, reported on `o_hdr4`. `o_hdr` carries the header dwords with dword 0 in bits 31:0, and bits 127:96 are zero for a 3-dword header. Both are valid on the beat with `o_sop` high.
- R2: For a 4-dword header, payload dword 0 is taken from input lane 4 when bit 2 of header dword 3 is clear, and from lane 5 when it is set.
- R3: For a 3-dword header, payload dword 0 is taken from input lane 4 when bit 2 of header dword 2 is clear, and from lane 3 when it is set.
- R4: The payload length in dwords is header dword 0 bits 9:0, with 0 meaning 1024. Output lane i of output beat j carries payload dword 8j+i. Lanes past the payload end are zero.
- R5: `o_sop` marks the first payload beat and `o_eop` the last. `o_empty` equals 8 minus the number of valid dwords on the last beat, and is 0 on every other beat.
- R6: A packet whose start and end share one input beat, and whose payload fits in that beat, yields exactly one output beat with both `o_sop` and `o_eop` high.
- R7: When payload dwords remain in the carry register after the final input beat, exactly one extra output beat with `o_eop` is produced. `i_ready` is low from the cycle after that final beat is accepted until the extra beat is issued.
- R8: While `o_valid` is high and `o_ready` is low, the output beat is held unchanged, and `i_ready` is low.
- R9: During and right after reset, `o_valid` is low and `i_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_valid | input | 1 | Input beat valid |
| i_ready | output | 1 | Block can take an input beat |
| i_data | input | 256 | Input beat, dword lane k in bits 32k+31:32k |
| i_sop | input | 1 | First beat of a packet |
| i_eop | input | 1 | Last beat of a packet |
| i_empty | input | 2 | Unused qwords at the top of the last beat |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Downstream takes the output beat |
| o_data | output | 256 | Payload beat, payload dword 8j+i in lane i |
| o_sop | output | 1 | First payload beat |
| o_eop | output | 1 | Last payload beat |
| o_empty | output | 3 | Unused dwords at the top of the last payload beat |
| o_hdr | output | 128 | Extracted header, valid with o_sop |
| o_hdr4 | output | 1 | Header is 4 dwords |

## Verification
The bench builds the block with its default length-field width of 10 bits. This puts the zero-means-1024 encoding within reach: one 1024-dword packet runs through the carry path across 128 output beats. Payload lengths on each side of the first-beat capacity (3, 4 or 5 dwords depending on the case) exercise the single-beat path, the carry path with and without a flush beat, and pad dwords on all four header/alignment layouts. Random downstream stalls test output holding and the ready path.

// File: rtl/tlp_rx_pkg.sv
// Shared constants and helpers for the payload realigner.
// Assumes 32-bit dwords and an eight-lane (256-bit) beat; header bit
// positions follow the transaction-layer header layout.
package tlp_rx_pkg;
    localparam int DW        = 32;
    localparam int LANES     = 8;
    localparam int BUS_W     = DW * LANES;
    localparam int HDR_W     = 4 * DW;
    localparam int LANE_IW   = $clog2(LANES);
    localparam int CNT_W     = LANE_IW + 1;
    localparam int QW_IW     = $clog2(LANES / 2);
    localparam int FMT4_BIT  = 29;
    localparam int ADDR2_BIT = 2;

    // Round a dword count up to a whole number of qwords (in dwords).
    function automatic int round_even(input int x);
        return (x + 1) & ~1;
    endfunction
endpackage

// File: rtl/tlp_hdr_decode.sv
// Header decoder: combinational. Reads the first beat of a packet and
// returns the header word, its size, the lane where payload starts and
// the payload length in dwords. Assumes the header sits in lanes 0..3.
module tlp_hdr_decode
    import tlp_rx_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic [BUS_W-1:0] beat_i,
    output logic [HDR_W-1:0] hdr_o,
    output logic             is4_o,
    output logic [CNT_W-1:0] off_o,
    output logic [LEN_W:0]   plen_o
);
    logic [DW-1:0] h0, h1, h2, h3;
    logic          unal;

    assign h0 = beat_i[0*DW +: DW];
    assign h1 = beat_i[1*DW +: DW];
    assign h2 = beat_i[2*DW +: DW];
    assign h3 = beat_i[3*DW +: DW];

    // Decode header size, alignment, start lane and length.
    always_comb begin
        is4_o = h0[FMT4_BIT];
        unal  = is4_o ? h3[ADDR2_BIT] : h2[ADDR2_BIT];
        if (is4_o) off_o = unal ? CNT_W'(5) : CNT_W'(4);
        else       off_o = unal ? CNT_W'(3) : CNT_W'(4);
        hdr_o  = {(is4_o ? h3 : '0), h2, h1, h0};
        plen_o = (h0[LEN_W-1:0] == '0) ? {1'b1, {LEN_W{1'b0}}}
                                       : {1'b0, h0[LEN_W-1:0]};
    end
endmodule

// File: rtl/tlp_lane_shift.sv
// Dword lane shifter: combinational. Moves every dword by amt_i lanes,
// toward higher lanes when TOWARD_HIGH is set, else toward lane 0.
// Vacated lanes read zero; an amount of LANES or more gives all zero.
module tlp_lane_shift
    import tlp_rx_pkg::*;
#(
    parameter bit TOWARD_HIGH = 1'b0
) (
    input  logic [BUS_W-1:0] data_i,
    input  logic [CNT_W-1:0] amt_i,
    output logic [BUS_W-1:0] data_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [DW-1:0] pick;

        // Select the source lane that lands in lane i.
        always_comb begin
            pick = '0;
            for (int s = 0; s < LANES; s++) begin
                if (TOWARD_HIGH ? (s + int'(amt_i) == i) : (i + int'(amt_i) == s))
                    pick = data_i[s*DW +: DW];
            end
        end

        assign data_o[i*DW +: DW] = pick;
    end
endmodule

// File: rtl/tlp_payload_realigner.sv
// Payload realigner top. Splits the header from each received packet and
// re-packs the payload from lane 0, carrying leftover dwords between beats
// and adding one flush beat when the carry outlives the input packet.
// Assumes well-formed input: one packet per beat, every packet carries at
// least one payload dword, and the end marker agrees with the length field.
module tlp_payload_realigner
    import tlp_rx_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               i_valid,
    output logic               i_ready,
    input  logic [BUS_W-1:0]   i_data,
    input  logic               i_sop,
    input  logic               i_eop,
    input  logic [QW_IW-1:0]   i_empty,
    output logic               o_valid,
    input  logic               o_ready,
    output logic [BUS_W-1:0]   o_data,
    output logic               o_sop,
    output logic               o_eop,
    output logic [LANE_IW-1:0] o_empty,
    output logic [HDR_W-1:0]   o_hdr,
    output logic               o_hdr4
);
    localparam int REM_W = LEN_W + 1;
    localparam int TOT_W = CNT_W + 1;
    localparam logic [REM_W-1:0] LANES_REM = REM_W'(LANES);
    localparam logic [CNT_W-1:0] LANES_CNT = CNT_W'(LANES);
    localparam logic [TOT_W-1:0] LANES_TOT = TOT_W'(LANES);

    // Packet state
    logic             in_pkt_q, in_pkt_d;
    logic [CNT_W-1:0] off_q, off_d;
    logic [REM_W-1:0] rem_q, rem_d;
    logic [HDR_W-1:0] hdr_q, hdr_d;
    logic             hdr4_q, hdr4_d;
    logic [BUS_W-1:0] carry_q, carry_d;
    logic             first_q, first_d;
    logic             flush_q, flush_d;
    logic [CNT_W-1:0] fcnt_q, fcnt_d;

    // Decoder and shifter signals
    logic [HDR_W-1:0] dec_hdr;
    logic             dec_is4;
    logic [CNT_W-1:0] dec_off;
    logic [REM_W-1:0] dec_plen;
    logic [CNT_W-1:0] off_sel, keep_cnt, cnt_in, sop_avail;
    logic [TOT_W-1:0] total;
    logic [BUS_W-1:0] shr_in, shl_in;
    logic             out_adv, acc, sop_fits;

    // Beat to emit
    logic             emit, e_sop, e_eop, e_hdr4;
    logic [BUS_W-1:0] e_data, e_mask;
    logic [CNT_W-1:0] e_cnt;
    logic [HDR_W-1:0] e_hdr;

    assign out_adv = !o_valid || o_ready;
    assign i_ready = out_adv && !flush_q;
    assign acc     = i_valid && i_ready;

    tlp_hdr_decode #(.LEN_W(LEN_W)) u_dec (
        .beat_i(i_data), .hdr_o(dec_hdr), .is4_o(dec_is4),
        .off_o(dec_off), .plen_o(dec_plen)
    );

    assign off_sel   = i_sop ? dec_off : off_q;
    assign keep_cnt  = LANES_CNT - off_q;
    assign sop_avail = LANES_CNT - dec_off;
    assign cnt_in    = (rem_q >= LANES_REM) ? LANES_CNT : rem_q[CNT_W-1:0];
    assign total     = {1'b0, keep_cnt} + {1'b0, cnt_in};
    assign sop_fits  = dec_plen <= {{(REM_W-CNT_W){1'b0}}, sop_avail};

    tlp_lane_shift #(.TOWARD_HIGH(1'b0)) u_shr (
        .data_i(i_data), .amt_i(off_sel), .data_o(shr_in)
    );
    tlp_lane_shift #(.TOWARD_HIGH(1'b1)) u_shl (
        .data_i(i_data), .amt_i(keep_cnt), .data_o(shl_in)
    );

    // Zero every output lane at or above the valid dword count.
    for (genvar i = 0; i < LANES; i++) begin : g_mask
        assign e_mask[i*DW +: DW] = (CNT_W'(i) < e_cnt) ? e_data[i*DW +: DW] : '0;
    end

    // Choose the beat to emit and the next packet state.
    always_comb begin
        emit = 1'b0; e_data = '0; e_cnt = '0; e_sop = 1'b0; e_eop = 1'b0;
        e_hdr = hdr_q; e_hdr4 = hdr4_q;
        in_pkt_d = in_pkt_q; off_d = off_q; rem_d = rem_q;
        hdr_d = hdr_q; hdr4_d = hdr4_q; carry_d = carry_q;
        first_d = first_q; flush_d = flush_q; fcnt_d = fcnt_q;
        if (flush_q) begin
            if (out_adv) begin
                emit = 1'b1; e_data = carry_q; e_cnt = fcnt_q;
                e_sop = first_q; e_eop = 1'b1;
                first_d = 1'b0; flush_d = 1'b0;
            end
        end else if (acc && i_sop) begin
            hdr_d = dec_hdr; hdr4_d = dec_is4; off_d = dec_off;
            if (sop_fits) begin
                emit = 1'b1; e_data = shr_in; e_cnt = dec_plen[CNT_W-1:0];
                e_sop = 1'b1; e_eop = 1'b1; e_hdr = dec_hdr; e_hdr4 = dec_is4;
                in_pkt_d = 1'b0; first_d = 1'b0;
            end else begin
                carry_d  = shr_in;
                rem_d    = dec_plen - {{(REM_W-CNT_W){1'b0}}, sop_avail};
                in_pkt_d = 1'b1; first_d = 1'b1;
            end
        end else if (acc && in_pkt_q) begin
            emit = 1'b1; e_data = carry_q | shl_in;
            e_sop = first_q; first_d = 1'b0;
            if (total <= LANES_TOT) begin
                e_cnt = total[CNT_W-1:0]; e_eop = 1'b1; in_pkt_d = 1'b0;
            end else begin
                e_cnt   = LANES_CNT;
                carry_d = shr_in;
                rem_d   = rem_q - {{(REM_W-CNT_W){1'b0}}, cnt_in};
                if (rem_q <= LANES_REM) begin
                    flush_d  = 1'b1;
                    fcnt_d   = CNT_W'(total - LANES_TOT);
                    in_pkt_d = 1'b0;
                end
            end
        end
    end

    // Packet state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_q <= 1'b0; off_q <= '0; rem_q <= '0; hdr_q <= '0;
            hdr4_q <= 1'b0; carry_q <= '0; first_q <= 1'b0;
            flush_q <= 1'b0; fcnt_q <= '0;
        end else begin
            in_pkt_q <= in_pkt_d; off_q <= off_d; rem_q <= rem_d; hdr_q <= hdr_d;
            hdr4_q <= hdr4_d; carry_q <= carry_d; first_q <= first_d;
            flush_q <= flush_d; fcnt_q <= fcnt_d;
        end
    end

    // Output register, advanced only when the current beat is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0; o_data <= '0; o_sop <= 1'b0; o_eop <= 1'b0;
            o_empty <= '0; o_hdr <= '0; o_hdr4 <= 1'b0;
        end else if (out_adv) begin
            o_valid <= emit;
            if (emit) begin
                o_data  <= e_mask;
                o_sop   <= e_sop;
                o_eop   <= e_eop;
                o_empty <= e_eop ? LANE_IW'(LANES_CNT - e_cnt) : '0;
                o_hdr   <= e_hdr;
                o_hdr4  <= e_hdr4;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> !o_valid);

    assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_eop)
                                   && $stable(o_sop) && $stable(o_empty)));

    assert_flush_gives_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && out_adv) |=> (o_valid && o_eop));

    assert_mid_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_eop) |-> (o_empty == '0));

    assert_short_hdr_top_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_sop && !o_hdr4) |-> (o_hdr[HDR_W-1 -: DW] == '0));

    assert_in_empty_agrees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && i_eop && (i_sop || in_pkt_q)) |->
        ((LANES - 2 * int'(i_empty)) ==
         (i_sop ? round_even(int'(dec_off) + int'(dec_plen)) : round_even(int'(rem_q)))));
endmodule

// File: tb/tlp_payload_realigner_bench.sv
module tlp_payload_realigner_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         i_valid, i_ready, i_sop, i_eop;
    logic [255:0] i_data;
    logic [1:0]   i_empty;
    logic         o_valid, o_ready, o_sop, o_eop, o_hdr4;
    logic [255:0] o_data;
    logic [2:0]   o_empty;
    logic [127:0] o_hdr;

    always #5 clk = ~clk;

    tlp_payload_realigner u_tlp_payload_realigner (
        .clk(clk), .rst_n(rst_n),
        .i_valid(i_valid), .i_ready(i_ready), .i_data(i_data),
        .i_sop(i_sop), .i_eop(i_eop), .i_empty(i_empty),
        .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data),
        .o_sop(o_sop), .o_eop(o_eop), .o_empty(o_empty),
        .o_hdr(o_hdr), .o_hdr4(o_hdr4)
    );

    typedef struct {
        logic [255:0] d;
        bit           sop, eop, fl;
        logic [1:0]   emp;
    } ibeat_t;

    typedef struct {
        logic [255:0] d;
        bit           sop, eop, is4, single;
        logic [2:0]   emp;
        logic [127:0] hdr;
    } obeat_t;

    ibeat_t in_q[$];
    obeat_t exp_q[$];
    int n_checks = 0;
    int n_err    = 0;
    localparam int LIMIT = 150000;

    task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Build one packet: input beats and the expected output beats.
    task automatic build_pkt(input bit is4, input bit unal, input logic [9:0] lenf);
        logic [31:0] h[4];
        logic [31:0] dq[$];
        logic [31:0] pq[$];
        int n, nb, ob, last;
        n = (lenf == 10'd0) ? 1024 : int'(lenf);
        for (int k = 0; k < 4; k++) h[k] = $urandom;
        h[0][29] = is4;
        h[0][9:0] = lenf;
        last = is4 ? 3 : 2;
        h[last][2] = unal;
        if (!is4) h[3] = 32'd0;
        for (int k = 0; k <= last; k++) dq.push_back(h[k]);
        if (is4 ? unal : !unal) dq.push_back($urandom);
        for (int k = 0; k < n; k++) pq.push_back($urandom);
        for (int k = 0; k < n; k++) dq.push_back(pq[k]);
        if (dq.size() % 2 == 1) dq.push_back($urandom);
        nb = (dq.size() + 7) / 8;
        ob = (n + 7) / 8;
        for (int b = 0; b < nb; b++) begin
            ibeat_t ib;
            int vcnt;
            vcnt = (dq.size() - 8 * b > 8) ? 8 : dq.size() - 8 * b;
            for (int l = 0; l < 8; l++)
                ib.d[l*32 +: 32] = (l < vcnt) ? dq[8*b + l] : $urandom;
            ib.sop = (b == 0);
            ib.eop = (b == nb - 1);
            ib.emp = ib.eop ? 2'((8 - vcnt) / 2) : 2'd0;
            ib.fl  = ib.eop && (nb >= 2) && (ob == nb);
            in_q.push_back(ib);
        end
        for (int j = 0; j < ob; j++) begin
            obeat_t e;
            int cnt;
            cnt = (n - 8 * j > 8) ? 8 : n - 8 * j;
            for (int l = 0; l < 8; l++)
                e.d[l*32 +: 32] = (l < cnt) ? pq[8*j + l] : 32'd0;
            e.sop = (j == 0);
            e.eop = (j == ob - 1);
            e.emp = e.eop ? 3'(8 - cnt) : 3'd0;
            e.hdr = {h[3], h[2], h[1], h[0]};
            e.is4 = is4;
            e.single = (nb == 1);
            exp_q.push_back(e);
        end
    endtask

    // Compare one transferred output beat with the model.
    task automatic check_out();
        obeat_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected output beat", o_data, 256'd0);
            return;
        end
        e = exp_q.pop_front();
        if (e.single)
            chk(o_data == e.d, "R6 single-beat payload", o_data, e.d);
        else if (e.is4)
            chk(o_data == e.d, "R2/R4 payload lanes (4-dword header)", o_data, e.d);
        else
            chk(o_data == e.d, "R3/R4 payload lanes (3-dword header)", o_data, e.d);
        chk(o_sop == e.sop && o_eop == e.eop, "R5 sop/eop", {o_sop, o_eop}, {e.sop, e.eop});
        chk(o_empty == e.emp, "R5 empty count", o_empty, e.emp);
        if (e.sop) begin
            chk(o_hdr == e.hdr, "R1 header word", o_hdr, e.hdr);
            chk(o_hdr4 == e.is4, "R1 header size flag", o_hdr4, e.is4);
        end
    endtask

    initial begin
        ibeat_t cur;
        bit acc_prev, flush_chk, stall_chk;
        logic [255:0] stall_d;
        int cyc;
        void'($urandom(32'd4321));
        rst_n = 1'b0; i_valid = 1'b0; i_data = '0; i_sop = 1'b0;
        i_eop = 1'b0; i_empty = '0; o_ready = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(o_valid == 1'b0, "R9 o_valid in reset", o_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(o_valid == 1'b0, "R9 o_valid after reset", o_valid, 0);
        chk(i_ready == 1'b1, "R9 i_ready after reset", i_ready, 1);

        // Directed lengths around the first-beat capacity for all layouts.
        for (int c = 0; c < 4; c++) begin
            int off, avail;
            bit is4, unal;
            is4 = c[1]; unal = c[0];
            off = is4 ? (unal ? 5 : 4) : (unal ? 3 : 4);
            avail = 8 - off;
            build_pkt(is4, unal, 10'd1);
            build_pkt(is4, unal, 10'(avail));
            build_pkt(is4, unal, 10'(avail + 1));
            build_pkt(is4, unal, 10'd8);
            build_pkt(is4, unal, 10'd9);
            build_pkt(is4, unal, 10'(8 + avail));
            build_pkt(is4, unal, 10'(8 + avail + 1));
            build_pkt(is4, unal, 10'd16);
        end
        build_pkt(1'b0, 1'b1, 10'd0);   // R4: zero length field means 1024
        for (int p = 0; p < 150; p++)
            build_pkt(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      10'($urandom_range(1, 40)));

        acc_prev = 0; flush_chk = 0; stall_chk = 0; stall_d = '0; cyc = 0;
        cur = '{d: '0, sop: 0, eop: 0, fl: 0, emp: '0};
        while ((exp_q.size() > 0 || in_q.size() > 0 || i_valid) && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            if (acc_prev) i_valid = 1'b0;
            if (!i_valid && in_q.size() > 0 && $urandom_range(0, 4) != 0) begin
                cur = in_q.pop_front();
                i_data = cur.d; i_sop = cur.sop; i_eop = cur.eop; i_empty = cur.emp;
                i_valid = 1'b1;
            end
            o_ready = ($urandom_range(0, 3) != 0);
            #1;
            if (flush_chk) begin
                chk(i_ready == 1'b0, "R7 i_ready low while flush beat pending", i_ready, 0);
                flush_chk = 0;
            end
            if (stall_chk) begin
                chk(o_valid && o_data == stall_d, "R8 beat held under stall", o_data, stall_d);
                stall_chk = 0;
            end
            if (o_valid && !o_ready)
                chk(i_ready == 1'b0, "R8 i_ready low under stall", i_ready, 0);
            if (o_valid && o_ready) check_out();
            else if (o_valid) begin
                stall_chk = 1;
                stall_d = o_data;
            end
            acc_prev = i_valid && i_ready;
            if (acc_prev && cur.fl) flush_chk = 1;
        end

        if (cyc >= LIMIT)
            chk(1'b0, "R5 watchdog expired, beats outstanding", 256'(exp_q.size()), 0);

        // R7: no beat beyond the expected flush beats.
        o_ready = 1'b1;
        repeat (10) begin
            @(negedge clk);
            #1;
            chk(o_valid == 1'b0, "R7 no extra output beat", o_valid, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule